// File: doc/BRIEF.md
# Write-Once Snooping Cache Controller

This block keeps a small direct-mapped data cache coherent on a shared snooping bus under the write-once policy. Each line holds one data word, an address tag and one of four coherence states: Invalid, Valid, Reserved or Dirty. The processor issues reads and writes through a request/ready handshake and stalls until the request completes. Misses and write-throughs go out as single-word bus read or write transactions. A Dirty line that has to make room for a new line is written back first.

A line's first write after a fill goes through to memory. Other caches see that write and drop their copies, so the line becomes Reserved and belongs to this cache alone. Later writes stay local and mark the line Dirty. A snoop port reports the transactions of other masters. When another master reads a Reserved line, that line falls back to Valid. When another master reads a Dirty line, the cache supplies the word for memory and the requester and the line becomes Valid. When another master writes to a line this cache holds, the line is invalidated.

Top module: `wo_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, `bus_req`, `cpu_ready` and `snp_intervene` are low, and the first access to any address misses.
- R2: A read miss issues one bus read (`bus_we`=0) at the request address and installs the returned word as Valid. A following read of that address returns the word with no bus transaction.
- R3: A write to a Valid line issues one bus write (`bus_we`=1) carrying the request address and data. The line becomes Reserved.
- R4: A write to a Reserved line issues no bus transaction and makes the line Dirty. Writes to a Dirty line also stay local. Later reads return the newest data.
- R5: A snooped read (`snp_we`=0) that hits a Reserved line leaves `snp_intervene` low and returns the line to Valid, so the next processor write is written through again.
- R6: A snooped read that hits a Dirty line raises `snp_intervene` in the same cycle, with the line's word on `snp_data`. The line then becomes Valid: a second snooped read does not intervene, and the next processor write is written through.
- R7: A snooped write (`snp_we`=1) that hits a Valid, Reserved or Dirty line invalidates it. The next processor read misses, and an invalidated Dirty line is not written back.
- R8: A miss that displaces a Dirty line first writes the old word back to the old line's address (old tag above the index), then issues the fill read. A displaced Valid or Reserved line is dropped with no bus write. The index is the low IDX_W address bits.
- R9: `cpu_ready` is a one-cycle pulse that marks completion. The processor holds its request until then. While a bus transaction waits for `bus_ack`, the controller keeps `bus_req`, `bus_addr` and `bus_we` steady.
- R10: In any cycle with `snp_valid` high, the controller does not start a processor lookup. If a snoop and a processor-side update change the same line in one cycle, the snoop's state change wins.
- R11: A write miss fills the line, then writes it through, leaving the line Reserved. A second write to it causes no bus transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Processor word address |
| cpu_wdata | input | DW | Processor write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DW | Read data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus transaction request |
| bus_we | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | AW | Bus transaction address |
| bus_wdata | output | DW | Bus write data |
| bus_ack | input | 1 | Transaction completes in this cycle |
| bus_rdata | input | DW | Bus read data, valid with `bus_ack` |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_we | input | 1 | 1 = snooped write, 0 = snooped read |
| snp_addr | input | AW | Snooped address |
| snp_intervene | output | 1 | Cache supplies data for a snooped read of a Dirty line |
| snp_data | output | DW | Intervention data |

## Verification
The bench steps each line through Valid, Reserved and Dirty and counts bus reads and writes per access. A design that deferred the first write, or wrote through every write, shows the wrong write count. Snooped reads are aimed at Reserved and at Dirty lines. Intervening on a Reserved line, or leaving a line Reserved or Dirty after the snoop, shows up either as an extra intervention or as a missing write-through on the next write. Snooped writes to Dirty lines check that the stale word is dropped and not written back. Dirty, Reserved and Valid victims at several indices check the write-back address. A processor request held under a long snoop must not reach the bus until the snoop ends.

// File: rtl/wo_snoop_cache.sv
module wo_snoop_cache #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int IDX_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic          cpu_ready,
  output logic [DW-1:0] cpu_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  input  logic          snp_valid,
  input  logic          snp_we,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_intervene,
  output logic [DW-1:0] snp_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int TW    = AW - IDX_W;

  typedef enum logic [1:0] {L_INV, L_VAL, L_RES, L_DRT} lst_t;
  typedef enum logic [2:0] {S_LOOK, S_WB, S_FILL, S_WT, S_RESP} fsm_t;

  lst_t          lst  [LINES];
  logic [TW-1:0] ltag [LINES];
  logic [DW-1:0] ldat [LINES];
  fsm_t          fsm;

  logic [IDX_W-1:0] cidx, sidx;
  logic [TW-1:0]    ctag, stag;
  logic             c_hit, s_hit;

  assign cidx  = cpu_addr[IDX_W-1:0];
  assign ctag  = cpu_addr[AW-1:IDX_W];
  assign sidx  = snp_addr[IDX_W-1:0];
  assign stag  = snp_addr[AW-1:IDX_W];
  assign c_hit = (lst[cidx] != L_INV) && (ltag[cidx] == ctag);
  assign s_hit = (lst[sidx] != L_INV) && (ltag[sidx] == stag);

  assign snp_intervene = snp_valid && !snp_we && s_hit && (lst[sidx] == L_DRT);
  assign snp_data      = ldat[sidx];

  assign cpu_ready = (fsm == S_RESP);
  assign bus_req   = (fsm == S_WB && lst[cidx] == L_DRT) || fsm == S_FILL || fsm == S_WT;
  assign bus_we    = (fsm == S_WB) || (fsm == S_WT);
  assign bus_addr  = (fsm == S_WB) ? {ltag[cidx], cidx} : cpu_addr;
  assign bus_wdata = (fsm == S_WB) ? ldat[cidx] : cpu_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm       <= S_LOOK;
      cpu_rdata <= '0;
      for (int i = 0; i < LINES; i++) lst[i] <= L_INV;
    end else begin
      case (fsm)
        S_LOOK:
          if (cpu_req && !snp_valid) begin
            if (c_hit) begin
              if (!cpu_we) begin
                cpu_rdata <= ldat[cidx];
                fsm       <= S_RESP;
              end else if (lst[cidx] == L_VAL) begin
                fsm <= S_WT;
              end else begin
                ldat[cidx] <= cpu_wdata;
                lst[cidx]  <= L_DRT;
                fsm        <= S_RESP;
              end
            end else begin
              fsm <= (lst[cidx] == L_DRT) ? S_WB : S_FILL;
            end
          end
        S_WB:
          if (lst[cidx] != L_DRT) begin
            fsm <= S_FILL;
          end else if (bus_ack) begin
            lst[cidx] <= L_INV;
            fsm       <= S_FILL;
          end
        S_FILL:
          if (bus_ack) begin
            lst[cidx]  <= L_VAL;
            ltag[cidx] <= ctag;
            ldat[cidx] <= bus_rdata;
            fsm        <= S_LOOK;
          end
        S_WT:
          if (bus_ack) begin
            if (c_hit) begin
              lst[cidx]  <= L_RES;
              ldat[cidx] <= cpu_wdata;
            end
            fsm <= S_RESP;
          end
        default: fsm <= S_LOOK;
      endcase
      if (snp_valid && s_hit) lst[sidx] <= snp_we ? L_INV : L_VAL;
    end
  end

  AST_PRIVATE_WRITE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_we && fsm == S_LOOK && !snp_valid && c_hit && lst[cidx] != L_VAL
    |=> !bus_req && cpu_ready); // R4
  AST_INTERVENE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    snp_intervene |=> lst[$past(sidx)] == L_VAL); // R6
  AST_SNOOP_WRITE_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_we && s_hit |=> lst[$past(sidx)] == L_INV); // R7
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready); // R9
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && !snp_valid |=> bus_req && $stable(bus_addr) && $stable(bus_we)); // R9
  AST_SNOOP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && fsm == S_LOOK |=> fsm == S_LOOK); // R10
endmodule

// File: tb/wo_snoop_cache_tb.sv
`timescale 1ns/1ps
module wo_snoop_cache_tb;
  localparam int AW = 8, DW = 16, IDX_W = 2;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ready, bus_req, bus_we, snp_intervene;
  logic [DW-1:0] cpu_rdata, bus_wdata, snp_data;
  logic [AW-1:0] bus_addr;
  logic bus_ack = 0;
  logic [DW-1:0] bus_rdata = '0;
  logic snp_valid = 0, snp_we = 0;
  logic [AW-1:0] snp_addr = '0;

  logic [DW-1:0] mem [256];
  int n_chk = 0, n_fail = 0, nbus_rd = 0, nbus_wr = 0;

  always #2.5 clk = ~clk;

  wo_snoop_cache #(.AW(AW), .DW(DW), .IDX_W(IDX_W)) u_dut (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_ready, .cpu_rdata,
    .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_ack, .bus_rdata,
    .snp_valid, .snp_we, .snp_addr, .snp_intervene, .snp_data);

  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack <= 0;
    end else if (bus_req) begin
      bus_ack   <= 1;
      bus_rdata <= mem[bus_addr];
      if (bus_we) begin
        mem[bus_addr] = bus_wdata;
        nbus_wr++;
      end else begin
        nbus_rd++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic [DW-1:0] rd, output int nr, output int nw);
    int r0, w0, t;
    r0 = nbus_rd; w0 = nbus_wr; t = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    do begin
      @(negedge clk); #1; t++;
    end while (!cpu_ready && t < 200);
    if (!cpu_ready) chk(0, "R9 no ready", 0, 1);
    rd = cpu_rdata; nr = nbus_rd - r0; nw = nbus_wr - w0;
    cpu_req = 0;
  endtask

  task automatic snoop(input logic we, input logic [AW-1:0] a, output logic iv, output logic [DW-1:0] d);
    @(negedge clk);
    snp_valid = 1; snp_we = we; snp_addr = a;
    #1; iv = snp_intervene; d = snp_data;
    @(negedge clk);
    snp_valid = 0;
    if (iv) mem[a] = d;
  endtask

  // {we, addr, wdata, check_rd, exp_rd, exp_bus_reads, exp_bus_writes}
  localparam int VW = 1 + AW + DW + 1 + DW + 2 + 2;
  localparam int NV = 14;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 8'h10, 16'h0000, 1'b1, 16'h1010, 2'd1, 2'd0},  // R1 R2 cold read miss
    {1'b0, 8'h10, 16'h0000, 1'b1, 16'h1010, 2'd0, 2'd0},  // R2 read hit
    {1'b1, 8'h10, 16'hAAAA, 1'b0, 16'h0000, 2'd0, 2'd1},  // R3 write-through
    {1'b1, 8'h10, 16'hBBBB, 1'b0, 16'h0000, 2'd0, 2'd0},  // R4 reserved -> dirty
    {1'b1, 8'h10, 16'hCCCC, 1'b0, 16'h0000, 2'd0, 2'd0},  // R4 dirty stays local
    {1'b0, 8'h10, 16'h0000, 1'b1, 16'hCCCC, 2'd0, 2'd0},  // R4 newest data
    {1'b0, 8'h20, 16'h0000, 1'b1, 16'h1020, 2'd1, 2'd1},  // R8 dirty victim
    {1'b0, 8'h10, 16'h0000, 1'b1, 16'hCCCC, 2'd1, 2'd0},  // R8 written-back data, clean victim
    {1'b1, 8'h31, 16'h1111, 1'b0, 16'h0000, 2'd1, 2'd1},  // R11 write miss
    {1'b1, 8'h31, 16'h2222, 1'b0, 16'h0000, 2'd0, 2'd0},  // R11 now reserved
    {1'b0, 8'h31, 16'h0000, 1'b1, 16'h2222, 2'd0, 2'd0},  // R11 read back
    {1'b0, 8'h35, 16'h0000, 1'b1, 16'h1035, 2'd1, 2'd1},  // R8 dirty victim index 1
    {1'b1, 8'h36, 16'h5555, 1'b0, 16'h0000, 2'd1, 2'd1},  // R11 write miss index 2
    {1'b0, 8'h0A, 16'h0000, 1'b1, 16'h100A, 2'd1, 2'd0}   // R8 reserved victim dropped
  };

  initial begin
    #1_000_000;
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd, sd;
    logic iv;
    int nr, nw;
    for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + DW'(i);

    repeat (3) @(negedge clk);
    #1;
    chk(!bus_req && !cpu_ready && !snp_intervene, "R1 reset outputs", {bus_req, cpu_ready, snp_intervene}, 0);
    @(negedge clk); rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      cpu_op(e[VW-1], e[VW-2 -: AW], e[VW-2-AW -: DW], rd, nr, nw);
      if (e[DW+4]) chk(rd == e[DW+3 -: DW], $sformatf("vec %0d rdata", v), rd, e[DW+3 -: DW]);
      chk(nr == int'(e[3:2]), $sformatf("vec %0d bus reads", v), nr, e[3:2]);
      chk(nw == int'(e[1:0]), $sformatf("vec %0d bus writes", v), nw, e[1:0]);
    end

    @(negedge clk); #1;
    chk(!cpu_ready, "R9 ready is one pulse", cpu_ready, 0);

    cpu_op(0, 8'h31, 0, rd, nr, nw);
    chk(rd == 16'h2222 && nw == 0, "R8 write-back reached memory", rd, 16'h2222);

    cpu_op(0, 8'h44, 0, rd, nr, nw);
    chk(rd == 16'h1044 && nr == 1, "R2 fill 0x44", rd, 16'h1044);
    cpu_op(1, 8'h44, 16'h7777, rd, nr, nw);
    chk(nw == 1, "R3 first write", nw, 1);
    snoop(0, 8'h44, iv, sd);
    chk(!iv, "R5 no intervention on reserved", iv, 0);
    cpu_op(1, 8'h44, 16'h8888, rd, nr, nw);
    chk(nw == 1, "R5 back to valid, write-through", nw, 1);
    cpu_op(1, 8'h44, 16'h9999, rd, nr, nw);
    chk(nw == 0, "R4 deferred write", nw, 0);
    snoop(0, 8'h84, iv, sd);
    chk(!iv, "R6 tag mismatch no intervention", iv, 0);
    snoop(0, 8'h44, iv, sd);
    chk(iv && sd == 16'h9999, "R6 intervention data", {iv, sd}, {1'b1, 16'h9999});
    snoop(0, 8'h44, iv, sd);
    chk(!iv, "R6 second snoop read clean", iv, 0);
    cpu_op(1, 8'h44, 16'hAAAA, rd, nr, nw);
    chk(nw == 1, "R6 valid after intervention", nw, 1);

    snoop(1, 8'h44, iv, sd);
    cpu_op(0, 8'h44, 0, rd, nr, nw);
    chk(nr == 1 && rd == 16'hAAAA, "R7 snoop write invalidates reserved", {nr[15:0], rd}, {16'd1, 16'hAAAA});
    cpu_op(1, 8'h44, 16'hBBBB, rd, nr, nw);
    cpu_op(1, 8'h44, 16'hCCCC, rd, nr, nw);
    chk(nw == 0, "R4 dirty again", nw, 0);
    snoop(1, 8'h44, iv, sd);
    cpu_op(0, 8'h44, 0, rd, nr, nw);
    chk(nr == 1 && nw == 0 && rd == 16'hBBBB, "R7 dirty dropped no write-back",
        {nr[7:0], nw[7:0], rd}, {8'd1, 8'd0, 16'hBBBB});

    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = 8'h60;
    snp_valid = 1; snp_we = 0; snp_addr = 8'h7F;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(!bus_req && !cpu_ready, "R10 lookup held during snoop", {bus_req, cpu_ready}, 0);
    end
    snp_valid = 0;
    begin
      int t;
      t = 0;
      do begin @(negedge clk); #1; t++; end while (!cpu_ready && t < 200);
    end
    chk(cpu_ready && cpu_rdata == 16'h1060, "R10 request completes after snoop", cpu_rdata, 16'h1060);
    cpu_req = 0;

    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule